// File: doc/BRIEF.md
# Dual-Channel Sample Demultiplexer with Shared Saturation Flag

This block sits behind a two-channel 8-bit converter core. It takes the in-phase (I) and quadrature (Q) sample streams at the full sample rate and places them on output buses. The samples are offset-binary codes. The block also reports on a single flag whether any of those samples sits at a rail.

The block has two modes. In pass-through mode each accepted sample appears on the primary buses one cycle later, with a strobe for every sample, and the secondary buses stay at zero. In pairing mode the block gathers two accepted samples per channel before it raises the strobe. The older sample of the pair goes on the secondary bus and the newer one on the primary bus. Each bus therefore updates at half the sample rate, and the secondary bus lags the primary bus by one sample. A Q-off select removes the Q channel from the flag decision.

Top module: `iq_demux_out`

## Requirements
- R1: After reset, every data bus is zero and both `out_valid` and `rng_flag` are low.
- R2: With `demux_en` low, each cycle with `in_valid` high puts `i_code`/`q_code` on `di`/`dq` in the next cycle and raises `out_valid` for one cycle. A cycle without `in_valid` gives no strobe.
- R3: While `demux_en` is low, `did` and `dqd` read zero from the cycle after it goes low.
- R4: With `demux_en` high, `out_valid` rises only after the second accepted sample of each pair, so there is one strobe for every two accepted samples.
- R5: With `demux_en` high, a strobe presents the newer sample of the pair on `di`/`dq` and the older sample on `did`/`dqd`.
- R6: `rng_flag` is high with a strobe when any sample the strobe covers has an I code of all zeros (8'h00) or all ones (8'hFF). With Q enabled, the same applies to a Q code of 8'h00 or 8'hFF.
- R7: While `q_pd` is high at the time a sample is accepted, that sample's Q code has no effect on `rng_flag`.
- R8: In a cycle where `out_valid` is low, `di`, `dq` and `rng_flag` keep their previous values.
- R9: A cycle with `demux_en` low discards any half-gathered pair. The first accepted sample after pairing mode resumes is the older sample of a new pair.
- R10: Cycles without `in_valid` between the two samples of a pair do not break the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| i_code | input | W | I channel sample, offset binary |
| q_code | input | W | Q channel sample, offset binary |
| in_valid | input | 1 | Sample accepted this cycle |
| demux_en | input | 1 | 1 = pairing mode, 0 = pass-through |
| q_pd | input | 1 | 1 = Q channel left out of the flag |
| di | output | W | Primary I bus (newer sample) |
| did | output | W | Secondary I bus (older sample) |
| dq | output | W | Primary Q bus (newer sample) |
| dqd | output | W | Secondary Q bus (older sample) |
| out_valid | output | 1 | One-cycle strobe for new bus contents |
| rng_flag | output | 1 | Saturation flag for the strobed sample(s) |

## Verification
The bench checks that the flag ORs in a rail code from the first sample of a pair even when the second sample is clean. A design that flagged only the latest sample would miss it. It splits pairs with idle cycles and aborts a pair by dropping out of pairing mode. A design that counted cycles instead of samples, or that kept a stale half-pair, would show swapped or shifted buses. It sets Q to a rail value while Q is off, which a design that ignored the select would flag. It also checks the secondary buses after a return to pass-through, where leftover pair data would show up as non-zero.

// File: rtl/iq_demux_pkg.sv
package iq_demux_pkg;

    // Position of the next accepted sample within a pair (pairing mode)
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } pair_ph_e;

    localparam int unsigned NUM_CH = 2;
    localparam int unsigned CH_I   = 0;
    localparam int unsigned CH_Q   = 1;

endpackage

// File: rtl/iq_range_det.sv
module iq_range_det #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] code,
    output logic         at_rail
);
    // A rail code is all zeros (below -FS) or all ones (above +FS)
    always_comb begin
        at_rail = (code == '0) || (code == '1);
    end
endmodule

// File: rtl/iq_flag_merge.sv
module iq_flag_merge #(
    parameter int unsigned NCH = 2
) (
    input  logic [NCH-1:0] rail,
    input  logic           q_off,
    output logic           hit
);
    // Channel 0 is I, channel 1 is Q; the Q-off select masks Q
    always_comb begin
        hit = rail[0] | (rail[1] & ~q_off);
    end
endmodule

// File: rtl/iq_demux_out.sv
module iq_demux_out
    import iq_demux_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] i_code,
    input  logic [W-1:0] q_code,
    input  logic         in_valid,
    input  logic         demux_en,
    input  logic         q_pd,
    output logic [W-1:0] di,
    output logic [W-1:0] did,
    output logic [W-1:0] dq,
    output logic [W-1:0] dqd,
    output logic         out_valid,
    output logic         rng_flag
);

    typedef struct packed {
        pair_ph_e     ph;
        logic [W-1:0] hold_i;
        logic [W-1:0] hold_q;
        logic         hold_hit;
        logic [W-1:0] di;
        logic [W-1:0] did;
        logic [W-1:0] dq;
        logic [W-1:0] dqd;
        logic         vld;
        logic         flag;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0]      ch_code [NUM_CH];
    logic [NUM_CH-1:0] ch_rail;
    logic              smp_hit;

    assign ch_code[CH_I] = i_code;
    assign ch_code[CH_Q] = q_code;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_rail
        iq_range_det #(.W(W)) u_det (
            .code    (ch_code[c]),
            .at_rail (ch_rail[c])
        );
    end

    iq_flag_merge #(.NCH(NUM_CH)) u_merge (
        .rail  (ch_rail),
        .q_off (q_pd),
        .hit   (smp_hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!demux_en) begin
            // Pass-through: drop any half pair, secondary buses at zero
            st_d.ph  = PH_FIRST;
            st_d.did = '0;
            st_d.dqd = '0;
            if (in_valid) begin
                st_d.di   = i_code;
                st_d.dq   = q_code;
                st_d.flag = smp_hit;
                st_d.vld  = 1'b1;
            end
        end else if (in_valid) begin
            if (st_q.ph == PH_FIRST) begin
                st_d.hold_i   = i_code;
                st_d.hold_q   = q_code;
                st_d.hold_hit = smp_hit;
                st_d.ph       = PH_SECOND;
            end else begin
                st_d.did  = st_q.hold_i;
                st_d.dqd  = st_q.hold_q;
                st_d.di   = i_code;
                st_d.dq   = q_code;
                st_d.flag = st_q.hold_hit | smp_hit;
                st_d.vld  = 1'b1;
                st_d.ph   = PH_FIRST;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign di        = st_q.di;
    assign did       = st_q.did;
    assign dq        = st_q.dq;
    assign dqd       = st_q.dqd;
    assign out_valid = st_q.vld;
    assign rng_flag  = st_q.flag;

endmodule

// File: rtl/iq_demux_out_chk.sv
module iq_demux_out_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] i_code,
    input logic [W-1:0] q_code,
    input logic         in_valid,
    input logic         demux_en,
    input logic         q_pd,
    input logic [W-1:0] di,
    input logic [W-1:0] did,
    input logic [W-1:0] dq,
    input logic [W-1:0] dqd,
    input logic         out_valid,
    input logic         rng_flag
);

    p_pass_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!demux_en && in_valid) |=> (out_valid && di == $past(i_code) && dq == $past(q_code)));

    p_no_strobe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_sec_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !demux_en |=> (did == '0 && dqd == '0));

    p_qoff_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!demux_en && in_valid && q_pd && i_code != '0 && i_code != '1) |=> !rng_flag);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(di) && $stable(dq) && $stable(rng_flag)));

    p_pair_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (demux_en && $past(demux_en) && out_valid) |-> !$past(out_valid));

endmodule

bind iq_demux_out iq_demux_out_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .i_code    (i_code),
    .q_code    (q_code),
    .in_valid  (in_valid),
    .demux_en  (demux_en),
    .q_pd      (q_pd),
    .di        (di),
    .did       (did),
    .dq        (dq),
    .dqd       (dqd),
    .out_valid (out_valid),
    .rng_flag  (rng_flag)
);

// File: tb/tb_iq_demux_out.sv
module tb_iq_demux_out;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] i_code = '0, q_code = '0;
    logic       in_valid = 1'b0, demux_en = 1'b0, q_pd = 1'b0;
    logic [7:0] di, did, dq, dqd;
    logic       out_valid, rng_flag;

    always #2 clk = ~clk;  // 250 MHz

    iq_demux_out #(.W(8)) dut (
        .clk(clk), .rst_n(rst_n), .i_code(i_code), .q_code(q_code),
        .in_valid(in_valid), .demux_en(demux_en), .q_pd(q_pd),
        .di(di), .did(did), .dq(dq), .dqd(dqd),
        .out_valid(out_valid), .rng_flag(rng_flag)
    );

    typedef struct packed {
        logic [7:0] di, did, dq, dqd;
        logic       f;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    // model of pairing state
    bit         m_ph = 0;
    logic [7:0] m_i, m_q;
    logic       m_f;

    function automatic logic rail(input logic [7:0] c);
        return (c == 8'h00) || (c == 8'hFF);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] i, input logic [7:0] q);
        logic f;
        exp_t e;
        @(negedge clk);
        i_code = i; q_code = q; in_valid = 1'b1;
        f = rail(i) | (!q_pd & rail(q));
        if (!demux_en) begin
            e = '{di: i, did: 8'h00, dq: q, dqd: 8'h00, f: f};
            sb.push_back(e);
        end else if (!m_ph) begin
            m_i = i; m_q = q; m_f = f; m_ph = 1;
        end else begin
            e = '{di: i, did: m_i, dq: q, dqd: m_q, f: m_f | f};
            sb.push_back(e);
            m_ph = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic set_mode(input logic d, input logic p);
        @(negedge clk);
        in_valid = 1'b0; demux_en = d; q_pd = p;
        if (!d) m_ph = 0;  // R9: a low cycle drops a half pair
    endtask

    // Monitor / scoreboard
    logic [7:0] last_di = '0, last_dq = '0;
    logic       last_f = 1'b0;
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R4 unexpected strobe", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check("R2/R5 di", int'(di), int'(e.di));
                    check("R2/R5 dq", int'(dq), int'(e.dq));
                    check("R3/R5 did", int'(did), int'(e.did));
                    check("R3/R5 dqd", int'(dqd), int'(e.dqd));
                    check("R6/R7 rng_flag", int'(rng_flag), int'(e.f));
                end
            end else begin
                check("R8 di hold", int'(di), int'(last_di));
                check("R8 dq hold", int'(dq), int'(last_dq));
                check("R8 flag hold", int'(rng_flag), int'(last_f));
            end
            last_di = di; last_dq = dq; last_f = rng_flag;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 di", int'(di), 0);
        check("R1 did", int'(did), 0);
        check("R1 dq", int'(dq), 0);
        check("R1 dqd", int'(dqd), 0);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 rng_flag", int'(rng_flag), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2, R6: pass-through, back to back and with gaps
        set_mode(0, 0);
        send(8'h40, 8'h80);
        send(8'h00, 8'h55);   // I at low rail
        idle(2);
        send(8'h33, 8'hFF);   // Q at high rail
        send(8'h7F, 8'h81);
        idle(2);

        // R7: Q off masks Q only
        set_mode(0, 1);
        send(8'h10, 8'hFF);   // no flag
        send(8'hFF, 8'h10);   // flag from I
        send(8'h20, 8'h00);   // no flag
        idle(2);

        // R4, R5, R6: pairing mode
        set_mode(1, 0);
        send(8'h01, 8'h02);
        send(8'h03, 8'h04);
        send(8'h00, 8'h30);   // rail in older sample only
        send(8'h21, 8'h31);
        send(8'h22, 8'h32);
        send(8'h23, 8'hFF);   // rail in newer Q
        idle(1);
        // R10: gaps inside a pair
        send(8'h44, 8'h54);
        idle(3);
        send(8'h45, 8'h55);
        idle(2);
        // R7 in pairing mode
        set_mode(1, 1);
        send(8'h60, 8'h00);
        send(8'h61, 8'hFF);
        idle(2);

        // R9: abort half pair
        set_mode(1, 0);
        send(8'hA0, 8'hB0);
        set_mode(0, 0);
        set_mode(1, 0);
        send(8'hA1, 8'hB1);
        send(8'hA2, 8'hB2);
        idle(2);

        // R3: secondary buses zero after return to pass-through
        set_mode(0, 0);
        idle(2);
        #1;
        check("R3 did zero", int'(did), 0);
        check("R3 dqd zero", int'(dqd), 0);
        send(8'h5A, 8'hA5);
        idle(4);

        // R4: no leftover expected items
        check("R4 scoreboard drained", sb.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule